// File: doc/BRIEF.md
# Address Translation Front-End with Fault Classification

This block sits between a processor's fetch and load/store paths and two translation lookaside buffers, one for instructions and one for data. It works out a translation mode from the status flags and handles each request in one of two ways. Some requests are answered directly with an identity mapping. The rest go to the TLB that matches the access type. The block then turns that TLB's result code into a physical address and rights, or into an exception cause.

One request is accepted at a time. A bypassed request completes one cycle after it is presented. A translated request completes one cycle after the selected TLB answers, so the TLB's own latency passes straight through. Completion is a one-cycle `done` strobe. In the same cycle, `fault` and the physical address are valid. The cause code, physical address and rights stay held until the next completion. On a fault, the virtual address is latched into a fault-address register, which keeps its value until the next fault.

Top module: `mmu_xlate_ctrl`

## Requirements
- R1: `xl_mode` is 0 when `mmu_en` is low, 1 when `mmu_en` and `sup_mode` are both high, and 2 when `mmu_en` is high and `sup_mode` is low.
- R2: With `mmu_en` low, the request raises neither TLB request line. It completes with `paddr` equal to the virtual address, `rights` = 3'b011 (bit0 read, bit1 write, bit2 execute), no fault and cause 0.
- R3: With `mmu_en` and `sup_mode` high and the address below 0x2000, the request is bypassed exactly as in R2. A user-mode access below 0x2000, or a supervisor access at 0x2000 or above, is translated.
- R4: A translated fetch (`req_kind` 0) raises only `itlb_req`. A load (`req_kind` 1) or store (`req_kind` 2) raises only `dtlb_req`. Both request lines are raised in the cycle the request is presented. `dtlb_write` is high only for stores, and the supervisor flag is forwarded to the TLB.
- R5: A TLB code of 1 (no match) or 2 (invalid entry) completes with a fault. The cause is 1 (instruction TLB miss) for a fetch and 2 (data TLB miss) for a load or store.
- R6: A TLB code of 3 (permission violation) completes with a fault. The cause is 3 (instruction page fault) for a fetch and 4 (data page fault) for a load or store.
- R7: A TLB code of 0 (hit) completes without a fault and with cause 0. `paddr` and `rights` take the values that the TLB returned.
- R8: On a faulting completion, `fault_vaddr` takes the request's virtual address. It keeps its value across every non-faulting completion.
- R9: `done` is high for exactly one cycle per request. For a TLB response in the L-th cycle after the request, `done` comes L+1 cycles after the request; for a bypass it comes 1 cycle after. `fault` is never high without `done`.
- R10: While a translated request is outstanding, new requests raise no TLB request. A response from the TLB that was not selected has no effect on the result.
- R11: `cause`, `paddr` and `rights` hold their completion values after `done` falls, until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present (accepted when idle) |
| req_vaddr | input | VA_W | Virtual address of the request |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| mmu_en | input | 1 | Translation enable flag |
| sup_mode | input | 1 | Supervisor privilege flag |
| itlb_req | output | 1 | Lookup strobe to the instruction TLB |
| itlb_vaddr | output | VA_W | Lookup address to the instruction TLB |
| itlb_sup | output | 1 | Privilege of the instruction lookup |
| itlb_rsp_valid | input | 1 | Instruction TLB answer present |
| itlb_rsp_code | input | 2 | Instruction TLB result code |
| itlb_rsp_paddr | input | PA_W | Instruction TLB physical address |
| itlb_rsp_rights | input | 3 | Instruction TLB rights |
| dtlb_req | output | 1 | Lookup strobe to the data TLB |
| dtlb_vaddr | output | VA_W | Lookup address to the data TLB |
| dtlb_sup | output | 1 | Privilege of the data lookup |
| dtlb_write | output | 1 | Data lookup is a store |
| dtlb_rsp_valid | input | 1 | Data TLB answer present |
| dtlb_rsp_code | input | 2 | Data TLB result code |
| dtlb_rsp_paddr | input | PA_W | Data TLB physical address |
| dtlb_rsp_rights | input | 3 | Data TLB rights |
| xl_mode | output | 2 | Current translation mode |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Completion raised an exception |
| cause | output | 3 | Exception cause, held |
| paddr | output | PA_W | Physical address, held |
| rights | output | 3 | Granted rights, held |
| fault_vaddr | output | VA_W | Address of the most recent fault |

## Verification
A wrong side flag or a stale captured address shows up at the first completion after the request. It appears as a swapped miss/page-fault cause or as a wrong `fault_vaddr`, and it is visible in the `done` cycle itself. A state machine that leaves the wait state too early or too late shows up as `done` arriving one cycle off, or never. A broken bypass decision shows up at once, in the request cycle, as a TLB request line rising when it should stay low. A lost hold shows up one cycle after `done`, when `cause` or `paddr` no longer match the completion values.

// File: rtl/mmu_fe_pkg.sv
package mmu_fe_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_kind_e;

    typedef enum logic [1:0] {
        TLB_HIT     = 2'd0,
        TLB_NOMATCH = 2'd1,
        TLB_INVALID = 2'd2,
        TLB_PERM    = 2'd3
    } tlb_code_e;

    typedef enum logic [2:0] {
        CAUSE_NONE  = 3'd0,
        CAUSE_IMISS = 3'd1,
        CAUSE_DMISS = 3'd2,
        CAUSE_IPF   = 3'd3,
        CAUSE_DPF   = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        XM_PHYS = 2'd0,
        XM_SUP  = 2'd1,
        XM_USER = 2'd2
    } xmode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } fe_state_e;

    // rights vector: bit0 read, bit1 write, bit2 execute
    localparam int          RIGHTS_W  = 3;
    localparam logic [2:0]  RIGHTS_RW = 3'b011;

    // index of each TLB in the router's side vectors
    localparam int SIDE_D = 0;
    localparam int SIDE_I = 1;
    localparam int N_SIDE = 2;

    function automatic xmode_e derive_mode(input logic en, input logic sup);
        if (!en)
            return XM_PHYS;
        return sup ? XM_SUP : XM_USER;
    endfunction

    function automatic cause_e classify(input logic fetch, input tlb_code_e code);
        case (code)
            TLB_NOMATCH, TLB_INVALID: return fetch ? CAUSE_IMISS : CAUSE_DMISS;
            TLB_PERM:                 return fetch ? CAUSE_IPF   : CAUSE_DPF;
            default:                  return CAUSE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mmu_mode_decode.sv
module mmu_mode_decode
    import mmu_fe_pkg::*;
#(
    parameter int          VA_W      = 32,
    parameter logic [31:0] LOW_LIMIT = 32'h0000_2000
) (
    input  logic            mmu_en,
    input  logic            sup_mode,
    input  logic [VA_W-1:0] vaddr,
    output xmode_e          mode,
    output logic            bypass
);
    localparam logic [VA_W-1:0] LIMIT_V = VA_W'(LOW_LIMIT);

    logic in_window;

    always_comb begin
        mode      = derive_mode(mmu_en, sup_mode);
        in_window = (vaddr < LIMIT_V);
        case (mode)
            XM_PHYS: bypass = 1'b1;
            XM_SUP:  bypass = in_window;
            default: bypass = 1'b0;
        endcase
    end
endmodule

// File: rtl/mmu_tlb_router.sv
module mmu_tlb_router
    import mmu_fe_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic                             issue,
    input  logic                             req_fetch,
    input  logic                             waiting,
    input  logic                             side_fetch,
    input  logic [N_SIDE-1:0]                rsp_valid,
    input  logic [N_SIDE-1:0][1:0]           rsp_code,
    input  logic [N_SIDE-1:0][PA_W-1:0]      rsp_paddr,
    input  logic [N_SIDE-1:0][RIGHTS_W-1:0]  rsp_rights,
    output logic [N_SIDE-1:0]                lookup,
    output logic                             sel_valid,
    output tlb_code_e                        sel_code,
    output logic [PA_W-1:0]                  sel_paddr,
    output logic [RIGHTS_W-1:0]              sel_rights
);
    logic [N_SIDE-1:0] side_on;

    for (genvar s = 0; s < N_SIDE; s++) begin : g_side
        localparam logic IS_INST = (s == SIDE_I);
        assign lookup[s]  = issue && (req_fetch == IS_INST);
        assign side_on[s] = waiting && (side_fetch == IS_INST);
    end

    always_comb begin
        sel_valid  = 1'b0;
        sel_code   = TLB_HIT;
        sel_paddr  = '0;
        sel_rights = '0;
        for (int s = 0; s < N_SIDE; s++) begin
            if (side_on[s]) begin
                sel_valid  = rsp_valid[s];
                sel_code   = tlb_code_e'(rsp_code[s]);
                sel_paddr  = rsp_paddr[s];
                sel_rights = rsp_rights[s];
            end
        end
    end
endmodule

// File: rtl/mmu_fault_classify.sv
module mmu_fault_classify
    import mmu_fe_pkg::*;
#(
    parameter int PA_W = 32
) (
    input  logic                side_fetch,
    input  tlb_code_e           code,
    input  logic [PA_W-1:0]     tlb_paddr,
    input  logic [RIGHTS_W-1:0] tlb_rights,
    output cause_e              cause,
    output logic                is_fault,
    output logic [PA_W-1:0]     res_paddr,
    output logic [RIGHTS_W-1:0] res_rights
);
    always_comb begin
        cause      = classify(side_fetch, code);
        is_fault   = (cause != CAUSE_NONE);
        res_paddr  = is_fault ? '0 : tlb_paddr;
        res_rights = is_fault ? '0 : tlb_rights;
    end
endmodule

// File: rtl/mmu_xlate_ctrl.sv
module mmu_xlate_ctrl
    import mmu_fe_pkg::*;
#(
    parameter int          VA_W      = 32,
    parameter int          PA_W      = 32,
    parameter logic [31:0] LOW_LIMIT = 32'h0000_2000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [1:0]      req_kind,
    input  logic            mmu_en,
    input  logic            sup_mode,
    output logic            itlb_req,
    output logic [VA_W-1:0] itlb_vaddr,
    output logic            itlb_sup,
    input  logic            itlb_rsp_valid,
    input  logic [1:0]      itlb_rsp_code,
    input  logic [PA_W-1:0] itlb_rsp_paddr,
    input  logic [2:0]      itlb_rsp_rights,
    output logic            dtlb_req,
    output logic [VA_W-1:0] dtlb_vaddr,
    output logic            dtlb_sup,
    output logic            dtlb_write,
    input  logic            dtlb_rsp_valid,
    input  logic [1:0]      dtlb_rsp_code,
    input  logic [PA_W-1:0] dtlb_rsp_paddr,
    input  logic [2:0]      dtlb_rsp_rights,
    output logic [1:0]      xl_mode,
    output logic            done,
    output logic            fault,
    output logic [2:0]      cause,
    output logic [PA_W-1:0] paddr,
    output logic [2:0]      rights,
    output logic [VA_W-1:0] fault_vaddr
);
    fe_state_e            state_q;
    logic                 side_q;
    logic [VA_W-1:0]      vaddr_q;
    logic                 done_q;
    logic                 fault_q;
    cause_e               cause_q;
    logic [PA_W-1:0]      paddr_q;
    logic [RIGHTS_W-1:0]  rights_q;
    logic [VA_W-1:0]      fva_q;

    xmode_e               mode;
    logic                 bypass;
    logic                 req_fetch;
    logic                 waiting;
    logic                 accept;
    logic                 issue;
    logic                 rsp_taken;

    logic [N_SIDE-1:0]               lookup;
    logic [N_SIDE-1:0]               rv;
    logic [N_SIDE-1:0][1:0]          rc;
    logic [N_SIDE-1:0][PA_W-1:0]     rp;
    logic [N_SIDE-1:0][RIGHTS_W-1:0] rr;

    logic                 sel_valid;
    tlb_code_e            sel_code;
    logic [PA_W-1:0]      sel_paddr;
    logic [RIGHTS_W-1:0]  sel_rights;
    cause_e               cls_cause;
    logic                 cls_fault;
    logic [PA_W-1:0]      cls_paddr;
    logic [RIGHTS_W-1:0]  cls_rights;

    assign req_fetch = (acc_kind_e'(req_kind) == ACC_FETCH);
    assign waiting   = (state_q == ST_WAIT);
    assign accept    = req_valid && !waiting;
    assign issue     = accept && !bypass;
    assign rsp_taken = sel_valid;

    mmu_mode_decode #(
        .VA_W      (VA_W),
        .LOW_LIMIT (LOW_LIMIT)
    ) u_mode (
        .mmu_en   (mmu_en),
        .sup_mode (sup_mode),
        .vaddr    (req_vaddr),
        .mode     (mode),
        .bypass   (bypass)
    );

    assign rv[SIDE_I] = itlb_rsp_valid;
    assign rc[SIDE_I] = itlb_rsp_code;
    assign rp[SIDE_I] = itlb_rsp_paddr;
    assign rr[SIDE_I] = itlb_rsp_rights;
    assign rv[SIDE_D] = dtlb_rsp_valid;
    assign rc[SIDE_D] = dtlb_rsp_code;
    assign rp[SIDE_D] = dtlb_rsp_paddr;
    assign rr[SIDE_D] = dtlb_rsp_rights;

    mmu_tlb_router #(
        .PA_W (PA_W)
    ) u_route (
        .issue      (issue),
        .req_fetch  (req_fetch),
        .waiting    (waiting),
        .side_fetch (side_q),
        .rsp_valid  (rv),
        .rsp_code   (rc),
        .rsp_paddr  (rp),
        .rsp_rights (rr),
        .lookup     (lookup),
        .sel_valid  (sel_valid),
        .sel_code   (sel_code),
        .sel_paddr  (sel_paddr),
        .sel_rights (sel_rights)
    );

    mmu_fault_classify #(
        .PA_W (PA_W)
    ) u_cls (
        .side_fetch (side_q),
        .code       (sel_code),
        .tlb_paddr  (sel_paddr),
        .tlb_rights (sel_rights),
        .cause      (cls_cause),
        .is_fault   (cls_fault),
        .res_paddr  (cls_paddr),
        .res_rights (cls_rights)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            side_q   <= 1'b0;
            vaddr_q  <= '0;
            done_q   <= 1'b0;
            fault_q  <= 1'b0;
            cause_q  <= CAUSE_NONE;
            paddr_q  <= '0;
            rights_q <= '0;
            fva_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                vaddr_q <= req_vaddr;
                side_q  <= req_fetch;
                if (bypass) begin
                    done_q   <= 1'b1;
                    fault_q  <= 1'b0;
                    cause_q  <= CAUSE_NONE;
                    paddr_q  <= PA_W'(req_vaddr);
                    rights_q <= RIGHTS_RW;
                end else begin
                    state_q <= ST_WAIT;
                end
            end
            if (rsp_taken) begin
                state_q  <= ST_IDLE;
                done_q   <= 1'b1;
                fault_q  <= cls_fault;
                cause_q  <= cls_cause;
                paddr_q  <= cls_paddr;
                rights_q <= cls_rights;
                if (cls_fault)
                    fva_q <= vaddr_q;
            end
        end
    end

    assign itlb_req    = lookup[SIDE_I];
    assign dtlb_req    = lookup[SIDE_D];
    assign itlb_vaddr  = req_vaddr;
    assign dtlb_vaddr  = req_vaddr;
    assign itlb_sup    = sup_mode;
    assign dtlb_sup    = sup_mode;
    assign dtlb_write  = (acc_kind_e'(req_kind) == ACC_STORE);
    assign xl_mode     = mode;
    assign done        = done_q;
    assign fault       = done_q && fault_q;
    assign cause       = cause_q;
    assign paddr       = paddr_q;
    assign rights      = rights_q;
    assign fault_vaddr = fva_q;
endmodule

// File: rtl/mmu_xlate_ctrl_chk.sv
module mmu_xlate_ctrl_chk #(
    parameter int          VA_W      = 32,
    parameter logic [31:0] LOW_LIMIT = 32'h0000_2000
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic [1:0]      req_kind,
    input logic            mmu_en,
    input logic            sup_mode,
    input logic            itlb_req,
    input logic            dtlb_req,
    input logic [1:0]      xl_mode,
    input logic            done,
    input logic            fault,
    input logic [2:0]      cause,
    input logic [VA_W-1:0] fault_vaddr,
    input logic [VA_W-1:0] vaddr_q,
    input logic            waiting,
    input logic            rsp_taken
);
    localparam logic [VA_W-1:0] LIM = VA_W'(LOW_LIMIT);

    p_user_mode_r1: assert property (@(posedge clk) disable iff (rst)
        (mmu_en && !sup_mode) |-> (xl_mode == 2'd2));

    p_off_no_lookup_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !waiting && !mmu_en) |-> (!itlb_req && !dtlb_req));

    p_low_window_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !waiting && mmu_en && sup_mode && (req_vaddr < LIM))
            |-> (!itlb_req && !dtlb_req));

    p_one_side_r4: assert property (@(posedge clk) disable iff (rst)
        !(itlb_req && dtlb_req));

    p_ifetch_only_r4: assert property (@(posedge clk) disable iff (rst)
        itlb_req |-> (req_kind == 2'd0));

    p_fault_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
        fault |-> (cause != 3'd0));

    p_clean_cause_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (cause == 3'd0));

    p_eear_load_r8: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (fault_vaddr == vaddr_q));

    p_eear_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !rsp_taken |=> $stable(fault_vaddr));

    p_fault_in_done_r9: assert property (@(posedge clk) disable iff (rst)
        fault |-> done);

    p_no_issue_busy_r10: assert property (@(posedge clk) disable iff (rst)
        waiting |-> (!itlb_req && !dtlb_req));

    p_cause_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!(req_valid && !waiting) && !rsp_taken) |=> $stable(cause));
endmodule

bind mmu_xlate_ctrl mmu_xlate_ctrl_chk #(
    .VA_W      (VA_W),
    .LOW_LIMIT (LOW_LIMIT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_vaddr   (req_vaddr),
    .req_kind    (req_kind),
    .mmu_en      (mmu_en),
    .sup_mode    (sup_mode),
    .itlb_req    (itlb_req),
    .dtlb_req    (dtlb_req),
    .xl_mode     (xl_mode),
    .done        (done),
    .fault       (fault),
    .cause       (cause),
    .fault_vaddr (fault_vaddr),
    .vaddr_q     (vaddr_q),
    .waiting     (waiting),
    .rsp_taken   (rsp_taken)
);

// File: tb/tb_mmu_xlate_ctrl.sv
`timescale 1ns/100ps
module tb_mmu_xlate_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        mmu_en = 1'b0;
    logic        sup_mode = 1'b0;
    logic        itlb_req, itlb_sup, dtlb_req, dtlb_sup, dtlb_write;
    logic [31:0] itlb_vaddr, dtlb_vaddr;
    logic        itlb_rsp_valid = 1'b0;
    logic [1:0]  itlb_rsp_code = '0;
    logic [31:0] itlb_rsp_paddr = '0;
    logic [2:0]  itlb_rsp_rights = '0;
    logic        dtlb_rsp_valid = 1'b0;
    logic [1:0]  dtlb_rsp_code = '0;
    logic [31:0] dtlb_rsp_paddr = '0;
    logic [2:0]  dtlb_rsp_rights = '0;
    logic [1:0]  xl_mode;
    logic        done, fault;
    logic [2:0]  cause, rights;
    logic [31:0] paddr, fault_vaddr;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_fva = '0;

    always #2.5 clk = ~clk;

    mmu_xlate_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .mmu_en(mmu_en), .sup_mode(sup_mode),
        .itlb_req(itlb_req), .itlb_vaddr(itlb_vaddr), .itlb_sup(itlb_sup),
        .itlb_rsp_valid(itlb_rsp_valid), .itlb_rsp_code(itlb_rsp_code),
        .itlb_rsp_paddr(itlb_rsp_paddr), .itlb_rsp_rights(itlb_rsp_rights),
        .dtlb_req(dtlb_req), .dtlb_vaddr(dtlb_vaddr), .dtlb_sup(dtlb_sup),
        .dtlb_write(dtlb_write), .dtlb_rsp_valid(dtlb_rsp_valid),
        .dtlb_rsp_code(dtlb_rsp_code), .dtlb_rsp_paddr(dtlb_rsp_paddr),
        .dtlb_rsp_rights(dtlb_rsp_rights), .xl_mode(xl_mode), .done(done),
        .fault(fault), .cause(cause), .paddr(paddr), .rights(rights),
        .fault_vaddr(fault_vaddr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(input int i);
        case (i)
            0:       return 32'h0000_0000;
            1:       return 32'h0000_1FFC;
            2:       return 32'h0000_2000;
            3:       return 32'h8000_1234;
            default: return 32'hFFFF_E004;
        endcase
    endfunction

    task automatic run_vec(input logic [31:0] va, input int kind, input int en,
                           input int sup, input int code, input int lat);
        logic        byp, fetch, exp_fault;
        logic [1:0]  exp_mode;
        logic [2:0]  exp_cause, exp_rights, drv_rights;
        logic [31:0] exp_pa, drv_pa;
        fetch    = (kind == 0);
        exp_mode = (en == 0) ? 2'd0 : ((sup != 0) ? 2'd1 : 2'd2);
        byp      = (en == 0) || ((sup != 0) && (va < 32'h2000));
        drv_pa     = va ^ 32'h5A5A_0000;
        drv_rights = {va[4], va[3], 1'b1} ^ 3'(kind);
        if (byp) begin
            exp_fault = 1'b0; exp_cause = 3'd0; exp_pa = va; exp_rights = 3'b011;
        end else if (code == 0) begin
            exp_fault = 1'b0; exp_cause = 3'd0; exp_pa = drv_pa; exp_rights = drv_rights;
        end else begin
            exp_fault  = 1'b1; exp_pa = '0; exp_rights = '0;
            if (code == 3) exp_cause = fetch ? 3'd3 : 3'd4;   // R6
            else           exp_cause = fetch ? 3'd1 : 3'd2;   // R5
        end

        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_kind = 2'(kind);
        mmu_en = 1'(en); sup_mode = 1'(sup);
        #1;
        chk("R1 xl_mode", 32'(xl_mode), 32'(exp_mode));
        chk("R2/R3 R4 itlb_req", 32'(itlb_req), 32'(!byp && fetch));
        chk("R2/R3 R4 dtlb_req", 32'(dtlb_req), 32'(!byp && !fetch));
        if (!byp && fetch) chk("R4 itlb_sup", 32'(itlb_sup), 32'(sup != 0));
        if (!byp && !fetch) begin
            chk("R4 dtlb_write", 32'(dtlb_write), 32'(kind == 2));
            chk("R4 dtlb_sup", 32'(dtlb_sup), 32'(sup != 0));
        end

        @(negedge clk);
        req_valid = 1'b0;
        if (!byp) begin
            for (int c = 1; c < lat; c++) begin
                chk("R9 early done", 32'(done), 32'd0);
                req_valid = 1'b1; req_vaddr = 32'h0000_0100; mmu_en = 1'b1;
                req_kind = fetch ? 2'd1 : 2'd0;
                if (fetch) begin
                    dtlb_rsp_valid = 1'b1; dtlb_rsp_code = 2'd0;
                    dtlb_rsp_paddr = 32'hDEAD_0000; dtlb_rsp_rights = 3'b111;
                end else begin
                    itlb_rsp_valid = 1'b1; itlb_rsp_code = 2'd0;
                    itlb_rsp_paddr = 32'hDEAD_0000; itlb_rsp_rights = 3'b111;
                end
                #1;
                chk("R10 busy itlb_req", 32'(itlb_req), 32'd0);
                chk("R10 busy dtlb_req", 32'(dtlb_req), 32'd0);
                @(negedge clk);
                req_valid = 1'b0; itlb_rsp_valid = 1'b0; dtlb_rsp_valid = 1'b0;
            end
            if (fetch) begin
                itlb_rsp_valid = 1'b1; itlb_rsp_code = 2'(code);
                itlb_rsp_paddr = drv_pa; itlb_rsp_rights = drv_rights;
            end else begin
                dtlb_rsp_valid = 1'b1; dtlb_rsp_code = 2'(code);
                dtlb_rsp_paddr = drv_pa; dtlb_rsp_rights = drv_rights;
            end
            @(negedge clk);
            itlb_rsp_valid = 1'b0; dtlb_rsp_valid = 1'b0;
        end
        if (exp_fault) exp_fva = va;
        chk("R9 done", 32'(done), 32'd1);
        chk("R5/R6/R7 fault", 32'(fault), 32'(exp_fault));
        chk("R5/R6/R7 cause", 32'(cause), 32'(exp_cause));
        chk("R2/R7 paddr", paddr, exp_pa);
        chk("R2/R7 rights", 32'(rights), 32'(exp_rights));
        chk("R8 fault_vaddr", fault_vaddr, exp_fva);
        @(negedge clk);
        chk("R9 done pulse", 32'(done), 32'd0);
        chk("R9 fault pulse", 32'(fault), 32'd0);
        chk("R11 cause held", 32'(cause), 32'(exp_cause));
        chk("R11 paddr held", paddr, exp_pa);
        chk("R11 rights held", 32'(rights), 32'(exp_rights));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("reset done", 32'(done), 32'd0);
        chk("reset fault", 32'(fault), 32'd0);
        chk("reset cause", 32'(cause), 32'd0);
        chk("reset paddr", paddr, 32'd0);
        chk("reset fault_vaddr", fault_vaddr, 32'd0);
        for (int en = 0; en < 2; en++)
            for (int sup = 0; sup < 2; sup++)
                for (int kind = 0; kind < 3; kind++)
                    for (int code = 0; code < 4; code++)
                        for (int a = 0; a < 5; a++)
                            run_vec(addr_of(a), kind, en, sup, code, 1 + ((a + code) % 3));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule